// File: doc/BRIEF.md
# DTMF Guard-Time Steering Controller

This block is the digital steering stage that follows a tone-pair detector. The detector supplies a flag that is high while a valid pair of tones is present, along with the 4-bit code of that pair. The controller accepts a digit only after the flag has stayed high, with the same code, for a programmable tone-present guard time. It then loads the code into an output latch. After a fixed settle delay it raises a digit-ready strobe.

The strobe stays high until the detector flag has been low for a programmable tone-absent guard time. Shorter dropouts therefore neither end the digit nor produce a second registration. An inhibit input can block the four extended digits; when it does, the latch keeps the previous code. An output-enable input gates the data bus, and the data bus is marked undriven through a separate enable output. Both guard times are given in clock ticks on input ports. A value of 0 behaves like 1.

Top module: `dtmf_steer`

## Requirements
- R1: While reset is asserted, and after it is released, `dout` is 0 and `digit_ready` is 0 until a digit is registered.
- R2: A digit is registered at the clock edge where `tone_valid` has been sampled high, with an unchanged `tone_code`, on `present_ticks` consecutive edges. At that edge `dout` takes the code.
- R3: A burst of `tone_valid` that is shorter than `present_ticks` samples leaves `dout` and `digit_ready` unchanged.
- R4: `digit_ready` rises exactly `SETTLE` clock edges after the edge that updates the latch (default 4).
- R5: `digit_ready` falls at the edge where `tone_valid` has been sampled low on `absent_ticks` consecutive edges. It stays high one edge earlier.
- R6: A low gap in `tone_valid` shorter than `absent_ticks` keeps `digit_ready` high and does not register a new code, even if the code changes after the gap.
- R7: A change of `tone_code` while `tone_valid` is high restarts the tone-present count.
- R8: With `block_ext` high, the codes 4'b1101, 4'b1110, 4'b1111 and 4'b0000 are not registered and `dout` keeps its value. Other codes still register. With `block_ext` low, those four codes register normally.
- R9: The latched code stays on `dout` after the tone ends, until the next registration.
- R10: `dout_en` follows `out_en` without a clock. A digit is still latched while `out_en` is low, and it appears once `out_en` is raised.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_valid | input | 1 | Detector flag: valid tone pair present |
| tone_code | input | 4 | Detector code for the present pair |
| block_ext | input | 1 | Blocks registration of the four extended digits |
| out_en | input | 1 | Data bus enable request |
| present_ticks | input | TW | Tone-present guard time in clock ticks |
| absent_ticks | input | TW | Tone-absent guard time in clock ticks |
| dout | output | 4 | Latched digit code |
| dout_en | output | 1 | Data bus driven (0 models high impedance) |
| digit_ready | output | 1 | Delayed steering strobe |

## Verification
Each input is driven just after a falling edge, so every rising edge samples it once. Outputs are read at falling edges, counted from the first sampling edge.

- The latch update is due at sample `present_ticks`, and the strobe rises `SETTLE` samples later.
- The strobe falls at low sample `absent_ticks`.
- The `dout_en` output is combinational, so it is read 1 time unit after `out_en` moves.

Each timing check reads the output one edge before the due edge and again at the due edge. This pins the result to a single cycle rather than to a window.

// File: rtl/dtmf_steer.sv
module dtmf_steer #(
  parameter int TW     = 16,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tone_valid,
  input  logic [3:0]    tone_code,
  input  logic          block_ext,
  input  logic          out_en,
  input  logic [TW-1:0] present_ticks,
  input  logic [TW-1:0] absent_ticks,
  output logic [3:0]    dout,
  output logic          dout_en,
  output logic          digit_ready
);
  localparam int SW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
  localparam logic [TW-1:0] CMAX = {TW{1'b1}};
  localparam logic [SW-1:0] SLAST = SW'(SETTLE - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_SETTLE = 2'd1, S_HELD = 2'd2;

  logic [1:0]    state;
  logic [TW-1:0] run_q, run_d, gap_q, gap_d;
  logic [3:0]    last_q, latch_q;
  logic [SW-1:0] scnt;
  logic          ext_code, take, release_now;

  always_comb begin
    if (!tone_valid)
      run_d = '0;
    else if (run_q != '0 && tone_code == last_q)
      run_d = (run_q == CMAX) ? run_q : run_q + 1'b1;
    else
      run_d = TW'(1);
  end

  always_comb begin
    if (tone_valid) gap_d = '0;
    else            gap_d = (gap_q == CMAX) ? gap_q : gap_q + 1'b1;
  end

  assign ext_code    = block_ext && (tone_code == 4'd0 || tone_code >= 4'd13);
  assign take        = (state == S_IDLE) && tone_valid && !ext_code && (run_d >= present_ticks);
  assign release_now = (state == S_HELD) && !tone_valid && (gap_d >= absent_ticks);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      gap_q   <= '0;
      last_q  <= '0;
      latch_q <= '0;
      scnt    <= '0;
      state   <= S_IDLE;
    end else begin
      run_q  <= run_d;
      gap_q  <= gap_d;
      last_q <= tone_code;
      case (state)
        S_IDLE: if (take) begin
          latch_q <= tone_code;
          scnt    <= '0;
          state   <= S_SETTLE;
        end
        S_SETTLE: if (scnt == SLAST) state <= S_HELD;
                  else scnt <= scnt + 1'b1;
        S_HELD: if (release_now) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dout        = latch_q;
  assign dout_en     = out_en;
  assign digit_ready = (state == S_HELD);
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk #(
  parameter int TW     = 16,
  parameter int SETTLE = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tone_valid,
  input logic       block_ext,
  input logic [3:0] dout,
  input logic       digit_ready,
  input logic [1:0] state
);
  localparam int CW = $clog2(SETTLE + 2) + 1;
  logic [CW-1:0] in_settle;

  always_ff @(posedge clk) begin
    if (!rst_n)                 in_settle <= '0;
    else if (state == 2'd1)     in_settle <= in_settle + 1'b1;
    else                        in_settle <= '0;
  end

  p_latch_needs_tone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(tone_valid));

  p_settle_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digit_ready) |-> (in_settle == CW'(SETTLE)));

  p_fall_on_absence_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(digit_ready) |-> !$past(tone_valid));

  p_no_reregister_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_ready && $past(digit_ready)) |-> $stable(dout));

  p_inhibit_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> !($past(block_ext) && (dout == 4'd0 || dout >= 4'd13)));
endmodule

bind dtmf_steer dtmf_steer_chk #(.TW(TW), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tone_valid(tone_valid), .block_ext(block_ext),
  .dout(dout), .digit_ready(digit_ready), .state(state)
);

// File: tb/tb_dtmf_steer.sv
module tb_dtmf_steer;
  localparam int CLK_P = 10;
  localparam int TW = 16;
  localparam int SETTLE = 4;
  localparam int TP = 6;
  localparam int TA = 5;

  logic clk = 1'b0;
  logic rst_n, tone_valid, block_ext, out_en;
  logic [3:0] tone_code;
  logic [TW-1:0] present_ticks, absent_ticks;
  logic [3:0] dout;
  logic dout_en, digit_ready;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dtmf_steer #(.TW(TW), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .tone_valid(tone_valid), .tone_code(tone_code),
    .block_ext(block_ext), .out_en(out_en), .present_ticks(present_ticks),
    .absent_ticks(absent_ticks), .dout(dout), .dout_en(dout_en),
    .digit_ready(digit_ready)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tone(input logic v, input logic [3:0] c);
    tone_valid = v;
    tone_code  = c;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tone(1'b0, 4'd0); block_ext = 1'b0; out_en = 1'b1;
    present_ticks = TW'(TP); absent_ticks = TW'(TA);
    step(3);
    chk("R1 dout in reset", dout, 0);
    chk("R1 ready in reset", digit_ready, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 dout after reset", dout, 0);
    chk("R1 ready after reset", digit_ready, 0);
  endtask

  task automatic t_basic;
    tone(1'b1, 4'd5);
    step(TP - 1);
    chk("R2 no latch one sample early", dout, 0);
    step(1);
    chk("R2 latch at guard", dout, 5);
    chk("R4 ready low at latch", digit_ready, 0);
    step(SETTLE - 1);
    chk("R4 ready low before settle", digit_ready, 0);
    step(1);
    chk("R4 ready after settle", digit_ready, 1);
    step(5);
    tone(1'b0, 4'd5);
    step(TA - 1);
    chk("R5 ready held before absent guard", digit_ready, 1);
    step(1);
    chk("R5 ready fall at absent guard", digit_ready, 0);
    chk("R9 code persists", dout, 5);
    step(5);
  endtask

  task automatic t_short;
    tone(1'b1, 4'd9);
    step(TP - 1);
    tone(1'b0, 4'd9);
    step(6);
    chk("R3 short burst dout", dout, 5);
    chk("R3 short burst ready", digit_ready, 0);
  endtask

  task automatic t_dropout;
    tone(1'b1, 4'd3);
    step(12);
    chk("R2 second digit", dout, 3);
    tone(1'b0, 4'd3);
    step(TA - 1);
    chk("R6 ready through dropout", digit_ready, 1);
    tone(1'b1, 4'd7);
    step(10);
    chk("R6 no second registration", dout, 3);
    chk("R6 ready still high", digit_ready, 1);
    tone(1'b0, 4'd7);
    step(TA);
    chk("R5 release after dropout case", digit_ready, 0);
    step(3);
  endtask

  task automatic t_code_change;
    tone(1'b1, 4'd1);
    step(4);
    tone(1'b1, 4'd2);
    step(TP - 1);
    chk("R7 count restarted", dout, 3);
    step(1);
    chk("R7 new code after full guard", dout, 2);
    tone(1'b0, 4'd2);
    step(12);
  endtask

  task automatic t_inhibit;
    block_ext = 1'b1;
    tone(1'b1, 4'd13);
    step(12);
    chk("R8 code 13 blocked", dout, 2);
    chk("R8 no strobe when blocked", digit_ready, 0);
    tone(1'b1, 4'd0);
    step(12);
    chk("R8 code 0 blocked", dout, 2);
    tone(1'b1, 4'd8);
    step(TP);
    chk("R8 plain code passes", dout, 8);
    tone(1'b0, 4'd8);
    step(12);
    block_ext = 1'b0;
    tone(1'b1, 4'd14);
    step(TP);
    chk("R8 code 14 without inhibit", dout, 14);
    tone(1'b0, 4'd14);
    step(12);
  endtask

  task automatic t_oe;
    out_en = 1'b0;
    #1;
    chk("R10 enable drops", dout_en, 0);
    step(1);
    tone(1'b1, 4'd6);
    step(TP);
    tone(1'b0, 4'd6);
    step(12);
    out_en = 1'b1;
    #1;
    chk("R10 enable rises", dout_en, 1);
    chk("R10 latched while disabled", dout, 6);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_basic;
    t_short;
    t_dropout;
    t_code_change;
    t_inhibit;
    t_oe;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule